// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers interrupt requests from peripheral sources into a bank of request flags, organised as five groups of four bits, twenty flags in all. Each flag has a matching enable bit. A single master enable gates all maskable flags. One flag belongs to the watchdog and always reaches the CPU. The controller gives the CPU one pending line and a 5-bit source number. The CPU raises an acknowledge to take the selected source, and that clears its flag.

Hardware sources pulse a one-cycle strobe per flag. One flag is not fed by a strobe but by four port pins combined with OR, and it is set on the rising edge of that combined signal. Software reaches every flag, enable bit and the master enable through a small register bus. Writing a 1 to a request bit raises a software interrupt, and writing a 0 withdraws one. When a hardware set and a clear of the same flag fall in the same cycle, the set wins, so no request is lost.

Top module: `irq_request_ctrl`

## Requirements
- R1: After a synchronous reset all request flags, all enable bits and the master enable read 0 and `irq_pending` is low.
- R2: A one-cycle strobe on `hw_req[i]` sets request flag i at the next rising clock edge. Flag i lives in request group i/4 at bit i%4.
- R3: A flag other than source 0 makes `irq_pending` high only while its enable bit and the master enable are both 1.
- R4: Source 0, the watchdog flag (group 0, bit 0), drives `irq_pending` high with `irq_src` = 0 whatever the enable bits and master enable hold.
- R5: Bus map with 4-bit addresses. Request group g (g = 0..4) is at address g, and enable group g is at address 8+g. The master enable is bit 0 at address 0xF, and bits 3:1 read 0. A write to a request group loads the written value, so a 1 sets a bit and a 0 clears it. Reads return the stored value. Every other address reads 0 and ignores writes.
- R6: Source 2 (group 0, bit 2) is set when the OR of the four `ext_pins` goes from 0 to 1. It is not set again while any pin stays high, even after software has cleared it.
- R7: Among eligible flags, the watchdog wins first. After it comes the lowest group, and within a group the highest bit. `irq_src` = 4*group + bit. When nothing is eligible, `irq_src` is 0.
- R8: With `irq_pending` high, `irq_ack` clears the flag named by `irq_src` at the next edge. With `irq_pending` low, `irq_ack` has no effect.
- R9: A hardware set of a flag in the same cycle as a software clear or an acknowledge of that flag leaves the flag at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 20 | One-cycle set strobes, one per source |
| ext_pins | input | 4 | Port pins whose OR forms external request source 2 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Register read data (combinational) |
| irq_ack | input | 1 | CPU acknowledge of the selected source |
| irq_pending | output | 1 | An eligible request exists |
| irq_src | output | 5 | Number of the selected source |

## Verification
Assertions check on every cycle the properties that can be stated locally. A strobe sets its flag on the next edge. An acknowledge clears its flag unless a set collides with it, and a set beats any same-cycle clear. The watchdog always owns the output, a masked controller stays quiet, the chosen source is really flagged, and an external edge never fires twice in a row. Only the bench scenarios can show the full priority order across mixed patterns and the exact bus map, including the dead addresses. They also show that a held pin does not re-raise its flag after software clears it, and that the second-ranked source takes over after an acknowledge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int DEF_GROUPS   = 5;
    localparam int DEF_GROUP_W  = 4;
    localparam int DEF_PINS     = 4;
    localparam int BUS_ADDR_W   = 4;
    localparam int WDOG_SRC     = 0;
    localparam int EXT_SRC      = 2;

    localparam logic [BUS_ADDR_W-1:0] MASTER_ADDR = 4'hF;

    typedef enum logic [1:0] {
        SEL_REQ,
        SEL_EN,
        SEL_MASTER,
        SEL_NONE
    } bus_sel_e;

    typedef struct packed {
        bus_sel_e   sel;
        logic [2:0] grp;
    } bus_dec_t;

    // Address bit 3 picks the request or enable bank, bits 2:0 the group.
    function automatic bus_dec_t decode_addr(logic [BUS_ADDR_W-1:0] a, int groups);
        bus_dec_t d;
        d.grp = a[2:0];
        if (a == MASTER_ADDR)
            d.sel = SEL_MASTER;
        else if (int'(a[2:0]) >= groups)
            d.sel = SEL_NONE;
        else if (a[3])
            d.sel = SEL_EN;
        else
            d.sel = SEL_REQ;
        return d;
    endfunction

endpackage

// File: rtl/irq_ext_edge.sv
module irq_ext_edge
    import irq_ctl_pkg::*;
#(
    parameter int PINS = DEF_PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins,
    output logic            evt
);
    logic any_now;
    logic any_q;

    assign any_now = |pins;

    always_ff @(posedge clk) begin
        if (rst) any_q <= 1'b0;
        else     any_q <= any_now;
    end

    assign evt = any_now & ~any_q;

    // R6: a held pin group produces one event, never two back to back
    a_r6_single_edge: assert property (@(posedge clk) disable iff (rst)
        evt |=> !evt);

endmodule

// File: rtl/irq_req_regs.sv
module irq_req_regs
    import irq_ctl_pkg::*;
#(
    parameter  int GROUPS  = DEF_GROUPS,
    parameter  int GROUP_W = DEF_GROUP_W,
    localparam int NSRC    = GROUPS * GROUP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       hw_set,
    input  logic [NSRC-1:0]       ack_clr,
    input  logic                  bus_we,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [GROUP_W-1:0]    bus_wdata,
    output logic [GROUP_W-1:0]    bus_rdata,
    output logic [NSRC-1:0]       req_q,
    output logic [NSRC-1:0]       en_q,
    output logic                  master_q
);
    bus_dec_t        dec;
    logic [NSRC-1:0] sw_set;
    logic [NSRC-1:0] sw_clr;
    logic [NSRC-1:0] req_d;

    assign dec = decode_addr(bus_addr, GROUPS);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic               hit_req;
        logic               hit_en;
        logic [GROUP_W-1:0] en_r;

        assign hit_req = bus_we && (dec.sel == SEL_REQ) && (dec.grp == 3'(g));
        assign hit_en  = bus_we && (dec.sel == SEL_EN)  && (dec.grp == 3'(g));

        assign sw_set[g*GROUP_W +: GROUP_W] = hit_req ?  bus_wdata : '0;
        assign sw_clr[g*GROUP_W +: GROUP_W] = hit_req ? ~bus_wdata : '0;

        always_ff @(posedge clk) begin
            if (rst)         en_r <= '0;
            else if (hit_en) en_r <= bus_wdata;
        end

        assign en_q[g*GROUP_W +: GROUP_W] = en_r;
    end

    // Sets of either kind dominate both kinds of clear.
    assign req_d = hw_set | sw_set | (req_q & ~sw_clr & ~ack_clr);

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            master_q <= 1'b0;
        else if (bus_we && dec.sel == SEL_MASTER)
            master_q <= bus_wdata[0];
    end

    always_comb begin
        unique case (dec.sel)
            SEL_REQ:    bus_rdata = req_q[int'(dec.grp)*GROUP_W +: GROUP_W];
            SEL_EN:     bus_rdata = en_q[int'(dec.grp)*GROUP_W +: GROUP_W];
            SEL_MASTER: bus_rdata = GROUP_W'(master_q);
            default:    bus_rdata = '0;
        endcase
    end

    // R1: reset empties every register
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (req_q == '0 && en_q == '0 && !master_q));

    // R2: a hardware strobe is visible in its flag one edge later
    a_r2_hw_sets: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((req_q & $past(hw_set)) == $past(hw_set)));

    // R8: an uncontested acknowledge removes its flag
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        ((ack_clr & ~hw_set & ~sw_set) != '0)
        |=> ((req_q & $past(ack_clr & ~hw_set & ~sw_set)) == '0));

    // R9: a colliding hardware set survives any clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((hw_set & (sw_clr | ack_clr)) != '0)
        |=> ((req_q & $past(hw_set & (sw_clr | ack_clr)))
             == $past(hw_set & (sw_clr | ack_clr))));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_ctl_pkg::*;
#(
    parameter  int GROUPS  = DEF_GROUPS,
    parameter  int GROUP_W = DEF_GROUP_W,
    localparam int NSRC    = GROUPS * GROUP_W,
    localparam int SRC_W   = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  en,
    input  logic             master,
    output logic             pending,
    output logic [SRC_W-1:0] src
);
    logic [NSRC-1:0] elig;

    always_comb begin
        elig           = req & en & {NSRC{master}};
        elig[WDOG_SRC] = req[WDOG_SRC];
    end

    // Later assignments override earlier ones: walk from the weakest
    // candidate to the strongest, then let the watchdog override all.
    always_comb begin
        pending = 1'b0;
        src     = '0;
        for (int g = GROUPS - 1; g >= 0; g--) begin
            for (int b = 0; b < GROUP_W; b++) begin
                if (elig[g*GROUP_W + b]) begin
                    pending = 1'b1;
                    src     = SRC_W'(g*GROUP_W + b);
                end
            end
        end
        if (elig[WDOG_SRC]) begin
            pending = 1'b1;
            src     = SRC_W'(WDOG_SRC);
        end
    end

    // R4: the watchdog flag owns the output regardless of masks
    a_r4_wdog_first: assert property (@(posedge clk) disable iff (rst)
        req[WDOG_SRC] |-> (pending && src == SRC_W'(WDOG_SRC)));

    // R3: with the master off only the watchdog may raise the line
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (!master && !req[WDOG_SRC]) |-> !pending);

    // R7: the selected source really carries a request
    a_r7_pick_flagged: assert property (@(posedge clk) disable iff (rst)
        pending |-> (((req >> src) & NSRC'(1)) != '0));

    // R7: no source number without a pending request
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !pending |-> (src == '0));

endmodule

// File: rtl/irq_request_ctrl.sv
module irq_request_ctrl
    import irq_ctl_pkg::*;
#(
    parameter  int GROUPS  = DEF_GROUPS,
    parameter  int GROUP_W = DEF_GROUP_W,
    parameter  int PINS    = DEF_PINS,
    localparam int NSRC    = GROUPS * GROUP_W,
    localparam int SRC_W   = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NSRC-1:0]       hw_req,
    input  logic [PINS-1:0]       ext_pins,
    input  logic                  bus_we,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [GROUP_W-1:0]    bus_wdata,
    output logic [GROUP_W-1:0]    bus_rdata,
    input  logic                  irq_ack,
    output logic                  irq_pending,
    output logic [SRC_W-1:0]      irq_src
);
    logic            ext_evt;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] ack_clr;
    logic [NSRC-1:0] req_q;
    logic [NSRC-1:0] en_q;
    logic            master_q;

    irq_ext_edge #(.PINS(PINS)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pins (ext_pins),
        .evt  (ext_evt)
    );

    assign hw_set  = hw_req | (NSRC'(ext_evt) << EXT_SRC);
    assign ack_clr = (irq_ack && irq_pending) ? (NSRC'(1) << irq_src) : '0;

    irq_req_regs #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .hw_set    (hw_set),
        .ack_clr   (ack_clr),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_q     (req_q),
        .en_q      (en_q),
        .master_q  (master_q)
    );

    irq_pick #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .req     (req_q),
        .en      (en_q),
        .master  (master_q),
        .pending (irq_pending),
        .src     (irq_src)
    );

endmodule

// File: tb/irq_request_ctrl_test.sv
`timescale 1ns/1ps
module irq_request_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] hw_req = '0;
    logic [3:0]  ext_pins = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_wdata = '0;
    logic [3:0]  bus_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_pending;
    logic [4:0]  irq_src;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_request_ctrl uut (
        .clk(clk), .rst(rst), .hw_req(hw_req), .ext_pins(ext_pins),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .irq_pending(irq_pending), .irq_src(irq_src)
    );

    typedef struct packed {
        logic [19:0] req;
        logic [19:0] en;
        logic        master;
        logic        pend;
        logic [4:0]  src;
        logic [3:0]  tag;   // 3: R3, 4: R4, 7: R7
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{20'h00001, 20'h00000, 1'b0, 1'b1, 5'd0,  4'd4},
        '{20'h00010, 20'h00010, 1'b0, 1'b0, 5'd0,  4'd3},
        '{20'h00010, 20'h00010, 1'b1, 1'b1, 5'd4,  4'd3},
        '{20'h00010, 20'hFFFEF, 1'b1, 1'b0, 5'd0,  4'd3},
        '{20'h000F0, 20'hFFFFF, 1'b1, 1'b1, 5'd7,  4'd7},
        '{20'h10100, 20'hFFFFF, 1'b1, 1'b1, 5'd8,  4'd7},
        '{20'h0000E, 20'hFFFFF, 1'b1, 1'b1, 5'd3,  4'd7},
        '{20'h80002, 20'hFFFFF, 1'b1, 1'b1, 5'd1,  4'd7},
        '{20'h80001, 20'h00000, 1'b0, 1'b1, 5'd0,  4'd4},
        '{20'h80000, 20'h80000, 1'b1, 1'b1, 5'd19, 4'd7},
        '{20'h00F00, 20'h00700, 1'b1, 1'b1, 5'd10, 4'd7}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic load(input logic [19:0] rq, input logic [19:0] en, input logic m);
        for (int g = 0; g < 5; g++) wr(4'(8 + g), en[g*4 +: 4]);
        for (int g = 0; g < 5; g++) wr(4'(g), rq[g*4 +: 4]);
        wr(4'hF, {3'b0, m});
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        logic [3:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: everything empty after reset
        for (int g = 0; g < 5; g++) begin
            rd(4'(g), d);     check("R1 request group", d, 0);
            rd(4'(8 + g), d); check("R1 enable group", d, 0);
        end
        rd(4'hF, d);
        check("R1 master", d, 0);
        check("R1 pending", irq_pending, 0);

        // R3 R4 R7 R5: table of register patterns
        foreach (VECS[i]) begin
            load(VECS[i].req, VECS[i].en, VECS[i].master);
            #1;
            check($sformatf("R%0d pending v%0d", VECS[i].tag, i), irq_pending, VECS[i].pend);
            check($sformatf("R%0d src v%0d", VECS[i].tag, i), irq_src, VECS[i].src);
        end

        // R5: readback, master layout, dead addresses
        load(20'h0, 20'h0, 1'b0);
        wr(4'hB, 4'hA);
        rd(4'hB, d); check("R5 enable readback", d, 4'hA);
        wr(4'hF, 4'hF);
        rd(4'hF, d); check("R5 master bit0 only", d, 4'h1);
        wr(4'h5, 4'hF);
        rd(4'h5, d); check("R5 dead addr 0x5", d, 0);
        wr(4'hD, 4'hF);
        rd(4'hD, d); check("R5 dead addr 0xD", d, 0);
        for (int g = 0; g < 5; g++) begin
            rd(4'(g), d); check("R5 dead writes leave requests", d, 0);
        end
        wr(4'h3, 4'h6);
        rd(4'h3, d); check("R5 request write sets", d, 4'h6);
        wr(4'h3, 4'h2);
        rd(4'h3, d); check("R5 request write clears", d, 4'h2);

        // R2: strobe on source 9 (group 2 bit 1)
        load(20'h0, 20'h0, 1'b0);
        @(negedge clk); hw_req = 20'h00200;
        @(negedge clk); hw_req = '0;
        #1 check("R2 flag not yet routed", irq_pending, 0);
        rd(4'h2, d); check("R2 flag set", d, 4'h2);
        wr(4'hA, 4'h2);
        wr(4'hF, 4'h1);
        #1 check("R2 pending", irq_pending, 1);
        check("R2 src", irq_src, 9);

        // R6: external pin group edge
        load(20'h0, 20'h0, 1'b0);
        @(negedge clk); ext_pins = 4'b0010;
        rd(4'h0, d); check("R6 rising edge sets source 2", d, 4'h4);
        wr(4'h0, 4'h0);
        rd(4'h0, d); check("R6 held pin no re-set", d, 0);
        @(negedge clk); ext_pins = 4'b0110;
        rd(4'h0, d); check("R6 second pin while held", d, 0);
        @(negedge clk); ext_pins = 4'b0000;
        @(negedge clk); ext_pins = 4'b1000;
        rd(4'h0, d); check("R6 new edge sets", d, 4'h4);
        @(negedge clk); ext_pins = 4'b0000;

        // R8: acknowledge walks down the priority order
        load(20'h00090, 20'h000F0, 1'b1);
        #1 check("R8 first src", irq_src, 7);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1 check("R8 next src", irq_src, 4);
        check("R8 still pending", irq_pending, 1);
        rd(4'h1, d); check("R8 acked bit cleared", d, 4'h1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        #1 check("R8 drained", irq_pending, 0);
        load(20'h00010, 20'h0, 1'b0);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        rd(4'h1, d); check("R8 ack without pending ignored", d, 4'h1);

        // R9: set beats software clear, set beats acknowledge
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h1; bus_wdata = 4'h0; hw_req = 20'h00010;
        @(negedge clk);
        bus_we = 1'b0; hw_req = '0;
        rd(4'h1, d); check("R9 set beats write clear", d, 4'h1);
        wr(4'h9, 4'h1);
        wr(4'hF, 4'h1);
        @(negedge clk); irq_ack = 1'b1; hw_req = 20'h00010;
        @(negedge clk); irq_ack = 1'b0; hw_req = '0;
        rd(4'h1, d); check("R9 set beats ack", d, 4'h1);
        check("R9 still pending", irq_pending, 1);

        done = 1'b1;
        report();
    end

endmodule